// File: doc/BRIEF.md
# Link Training Insertion Scheduler

This block decides, cycle by cycle, when a packet transmitter has to stop sending payload and put a link training sequence on the wire instead. While the link is enabled it counts the clock cycles spent outside training. Once the programmed interval is used up, it starts a training sequence whose length is a repeat count times a fixed number of cycles per pattern. Throughout the sequence the upstream data path is stalled.

An optional hold-off protects the opening burst of a packet, which is the burst that carries start-of-packet. When the hold-off is on, training waits until a programmed number of 8-byte blocks of that burst has been accepted, so the interval can stretch by at most that burst. Later bursts of the same packet get no such protection. Error logic elsewhere can force training. A forced request turns into continuous training that lasts until the link enable is dropped.

The scheduler drives only the request strobe, the active flag and the stall. The training pattern itself is generated downstream.

Top module: `link_trn_sched`

## Requirements
- R1: While `rst_n` or `link_en` is low, `trn_act` and `trn_req` are low on the next clock edge and the interval count restarts, so re-enabling the link gives a full interval of `max_gap` cycles before training.
- R2: With a legal interval and no hold-off, `trn_act` rises on the `max_gap`-th rising edge after `link_en` is first sampled high. Between two sequences there are exactly `max_gap` cycles with `trn_act` low.
- R3: A periodic sequence keeps `trn_act` high for `rep_cnt * TRN_UNIT` cycles (TRN_UNIT = 4 by default). `trn_req` is high for one cycle, the first cycle of each sequence, and only while `trn_act` is high.
- R4: When `max_gap` is 0 or `rep_cnt` is 0, no periodic training is ever started and `cfg_err` stays low.
- R5: When `max_gap` and `rep_cnt` are both nonzero but `max_gap` is not a multiple of 4 or is below MIN_GAP (32 by default), `cfg_err` is high while `link_en` is high and no periodic training is started.
- R6: `dat_stall` equals `trn_act` in every cycle.
- R7: When `hold_en` is high and a beat with `dat_sop` high is accepted (`dat_vld` high, `trn_act` low), training that falls due is deferred. It starts on the clock edge after the `min_blk * CYC_PER_BLK`-th consecutive accepted beat of that burst (CYC_PER_BLK = 4 by default).
- R8: A burst that starts without `dat_sop`, or any burst while `hold_en` is low, is cut by training exactly when the interval expires.
- R9: With a legal configuration, a run of cycles with `trn_act` low never exceeds `max_gap + min_blk * CYC_PER_BLK`.
- R10: `force_trn` sampled high while `link_en` is high makes `trn_act` rise on the next edge. `trn_act` then stays high, with a `trn_req` pulse every `rep_cnt * TRN_UNIT` cycles, until `link_en` goes low. After re-enable, normal periodic timing resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_en | input | 1 | Interface enable; low clears all scheduling state |
| max_gap | input | 16 | Cycles between training sequences; 0 disables |
| rep_cnt | input | 16 | Training patterns per sequence; 0 disables periodic training |
| hold_en | input | 1 | Enables the opening-burst hold-off |
| min_blk | input | 9 | Minimum opening burst in 8-byte blocks (even values expected) |
| dat_vld | input | 1 | Upstream has a data beat this cycle |
| dat_sop | input | 1 | The beat carries start-of-packet |
| force_trn | input | 1 | Fatal loss-of-sync; requests continuous training |
| trn_req | output | 1 | One-cycle strobe at the start of each training sequence |
| trn_act | output | 1 | Training sequence in progress |
| dat_stall | output | 1 | Upstream must hold its data |
| cfg_err | output | 1 | Interval value is misaligned or too small |

## Verification
A table of interval and repeat settings, with the data bus idle, separates the exact interval and sequence length from off-by-one variants. The same table shows that the two disabling values and the two kinds of illegal interval produce no training. Three runs of one continuous data burst, which are identical except for the start-of-packet flag and the hold-off enable, tell a correct hold-off apart from one that also protects non-opening bursts or ignores the enable. A forced-training run checks that training stays on continuously, that the strobe repeats, and that re-enabling clears the fatal state. A mid-interval enable drop checks that the count restarts.

// File: rtl/lts_pkg.sv
package lts_pkg;

   // Interval legality: aligned to 4 cycles and not shorter than the floor.
   function automatic logic gap_is_legal(input int unsigned gap, input int unsigned min_gap);
      return ((gap % 4) == 0) && (gap >= min_gap);
   endfunction

   // Sequence length with a floor of one pattern, used when a forced
   // sequence runs with a zero repeat count.
   function automatic int unsigned seq_cycles(input int unsigned rep, input int unsigned unit);
      return (rep == 0) ? unit : rep * unit;
   endfunction

endpackage

// File: rtl/lts_gap_timer.sv
module lts_gap_timer #(
   parameter int GAP_W   = 16,
   parameter int REP_W   = 16,
   parameter int MIN_GAP = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_en,
   input  logic             trn_act,
   input  logic [GAP_W-1:0] max_gap,
   input  logic [REP_W-1:0] rep_cnt,
   output logic             due,
   output logic             cfg_err
);
   import lts_pkg::*;

   localparam int CNT_W = GAP_W + 1;

   logic [CNT_W-1:0] gap_q;
   logic             asked;
   logic             legal;
   logic [CNT_W:0]   next_cnt;

   assign asked    = (max_gap != '0) && (rep_cnt != '0);
   assign legal    = gap_is_legal(32'(max_gap), 32'(MIN_GAP));
   assign cfg_err  = link_en && asked && !legal;
   assign next_cnt = {1'b0, gap_q} + 1'b1;
   assign due      = link_en && asked && legal && !trn_act &&
                     (next_cnt >= {2'b00, max_gap});

   always_ff @(posedge clk) begin
      if (!rst_n || !link_en || trn_act) begin
         gap_q <= '0;
      end else if (gap_q != '1) begin
         gap_q <= gap_q + 1'b1;
      end
   end

endmodule

// File: rtl/lts_burst_guard.sv
module lts_burst_guard #(
   parameter int MINB_W      = 9,
   parameter int CYC_PER_BLK = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_en,
   input  logic              hold_en,
   input  logic [MINB_W-1:0] min_blk,
   input  logic              dat_vld,
   input  logic              dat_sop,
   input  logic              trn_act,
   output logic              hold
);
   localparam int BEAT_W = MINB_W + $clog2(CYC_PER_BLK + 1) + 1;

   logic [BEAT_W-1:0] cnt_q;
   logic              first_q;
   logic [BEAT_W-1:0] target;
   logic [BEAT_W-1:0] beats_now;
   logic              beat_go;
   logic              in_first;

   assign target    = BEAT_W'(min_blk) * BEAT_W'(CYC_PER_BLK);
   assign beat_go   = dat_vld && !trn_act;
   assign in_first  = dat_sop || first_q;
   assign beats_now = dat_sop ? BEAT_W'(1) : cnt_q + BEAT_W'(1);
   assign hold      = hold_en && beat_go && in_first && (beats_now < target);

   always_ff @(posedge clk) begin
      if (!rst_n || !link_en || trn_act) begin
         cnt_q   <= '0;
         first_q <= 1'b0;
      end else if (beat_go && in_first) begin
         cnt_q   <= beats_now;
         first_q <= (beats_now < target);
      end else begin
         first_q <= 1'b0;
      end
   end

endmodule

// File: rtl/lts_seq_ctrl.sv
module lts_seq_ctrl #(
   parameter int REP_W    = 16,
   parameter int TRN_UNIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_en,
   input  logic             start,
   input  logic             force_trn,
   input  logic [REP_W-1:0] rep_cnt,
   output logic             trn_act,
   output logic             trn_req
);
   import lts_pkg::*;

   localparam int LEN_W = REP_W + $clog2(TRN_UNIT + 1) + 1;

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] seq_len;
   logic             act_q;
   logic             req_q;
   logic             fatal_q;
   logic             fatal;
   logic             last;

   assign seq_len = LEN_W'(seq_cycles(32'(rep_cnt), 32'(TRN_UNIT)));
   assign fatal   = fatal_q || force_trn;
   assign last    = (cnt_q == seq_len - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n || !link_en) begin
         act_q   <= 1'b0;
         req_q   <= 1'b0;
         cnt_q   <= '0;
         fatal_q <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (force_trn) fatal_q <= 1'b1;
         if (!act_q) begin
            if (start || fatal) begin
               act_q <= 1'b1;
               req_q <= 1'b1;
               cnt_q <= '0;
            end
         end else if (last) begin
            cnt_q <= '0;
            if (fatal) req_q <= 1'b1;
            else       act_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign trn_act = act_q;
   assign trn_req = req_q;

endmodule

// File: rtl/link_trn_sched.sv
module link_trn_sched #(
   parameter int GAP_W       = 16,
   parameter int REP_W       = 16,
   parameter int MINB_W      = 9,
   parameter int TRN_UNIT    = 4,
   parameter int CYC_PER_BLK = 4,
   parameter int MIN_GAP     = 32,
   parameter bit HOLD_OFF_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_en,
   input  logic [GAP_W-1:0]  max_gap,
   input  logic [REP_W-1:0]  rep_cnt,
   input  logic              hold_en,
   input  logic [MINB_W-1:0] min_blk,
   input  logic              dat_vld,
   input  logic              dat_sop,
   input  logic              force_trn,
   output logic              trn_req,
   output logic              trn_act,
   output logic              dat_stall,
   output logic              cfg_err
);

   if (TRN_UNIT < 1)                 $error("TRN_UNIT must be at least 1");
   if (CYC_PER_BLK < 1)              $error("CYC_PER_BLK must be at least 1");
   if ((MIN_GAP % 4) != 0)           $error("MIN_GAP must be a multiple of 4");
   if (MIN_GAP >= (1 << GAP_W))      $error("MIN_GAP does not fit in GAP_W");
   if (GAP_W < 4 || GAP_W > 30)      $error("GAP_W out of range");

   logic due;
   logic hold;
   logic start;

   lts_gap_timer #(
      .GAP_W(GAP_W), .REP_W(REP_W), .MIN_GAP(MIN_GAP)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .link_en(link_en), .trn_act(trn_act),
      .max_gap(max_gap), .rep_cnt(rep_cnt), .due(due), .cfg_err(cfg_err)
   );

   if (HOLD_OFF_EN) begin : g_guard
      lts_burst_guard #(
         .MINB_W(MINB_W), .CYC_PER_BLK(CYC_PER_BLK)
      ) u_guard (
         .clk(clk), .rst_n(rst_n), .link_en(link_en), .hold_en(hold_en),
         .min_blk(min_blk), .dat_vld(dat_vld), .dat_sop(dat_sop),
         .trn_act(trn_act), .hold(hold)
      );
   end else begin : g_noguard
      assign hold = 1'b0;
   end

   assign start = due && !hold;

   lts_seq_ctrl #(
      .REP_W(REP_W), .TRN_UNIT(TRN_UNIT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .link_en(link_en), .start(start),
      .force_trn(force_trn), .rep_cnt(rep_cnt),
      .trn_act(trn_act), .trn_req(trn_req)
   );

   assign dat_stall = trn_act;

endmodule

// File: rtl/lts_sched_chk.sv
module lts_sched_chk #(
   parameter int GAP_W       = 16,
   parameter int REP_W       = 16,
   parameter int MINB_W      = 9,
   parameter int CYC_PER_BLK = 4,
   parameter int MIN_GAP     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              link_en,
   input logic [GAP_W-1:0]  max_gap,
   input logic [REP_W-1:0]  rep_cnt,
   input logic [MINB_W-1:0] min_blk,
   input logic              force_trn,
   input logic              trn_req,
   input logic              trn_act,
   input logic              cfg_err
);
   logic [31:0] run_q;
   logic        legal;

   assign legal = (max_gap != '0) && (rep_cnt != '0) && (max_gap[1:0] == 2'b00) &&
                  (32'(max_gap) >= 32'(MIN_GAP));

   always_ff @(posedge clk) begin
      if (!rst_n || !link_en || trn_act) run_q <= '0;
      else if (run_q != '1)              run_q <= run_q + 1'b1;
   end

   assert_off_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !link_en |=> (!trn_act && !trn_req));

   assert_req_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trn_req |-> trn_act);

   assert_rise_has_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trn_act) |-> trn_req);

   assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (link_en && !trn_act && !force_trn && (max_gap == '0 || rep_cnt == '0))
      |=> !trn_act);

   assert_bad_cfg_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (link_en && !trn_act && !force_trn && cfg_err) |=> !trn_act);

   assert_gap_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (link_en && legal && !force_trn) |->
      (run_q <= 32'(max_gap) + 32'(min_blk) * 32'(CYC_PER_BLK)));

   assert_force_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (link_en && force_trn) |=> (trn_act || !link_en));

endmodule

bind link_trn_sched lts_sched_chk #(
   .GAP_W(GAP_W), .REP_W(REP_W), .MINB_W(MINB_W),
   .CYC_PER_BLK(CYC_PER_BLK), .MIN_GAP(MIN_GAP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .link_en(link_en), .max_gap(max_gap),
   .rep_cnt(rep_cnt), .min_blk(min_blk), .force_trn(force_trn),
   .trn_req(trn_req), .trn_act(trn_act), .cfg_err(cfg_err)
);

// File: tb/tb_link_trn_sched.sv
`timescale 1ns/1ps
module tb_link_trn_sched;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_en = 1'b0;
   logic [15:0] max_gap = '0;
   logic [15:0] rep_cnt = '0;
   logic        hold_en = 1'b0;
   logic [8:0]  min_blk = '0;
   logic        dat_vld = 1'b0;
   logic        dat_sop = 1'b0;
   logic        force_trn = 1'b0;
   logic        trn_req, trn_act, dat_stall, cfg_err;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   link_trn_sched dut (
      .clk(clk), .rst_n(rst_n), .link_en(link_en), .max_gap(max_gap),
      .rep_cnt(rep_cnt), .hold_en(hold_en), .min_blk(min_blk),
      .dat_vld(dat_vld), .dat_sop(dat_sop), .force_trn(force_trn),
      .trn_req(trn_req), .trn_act(trn_act), .dat_stall(dat_stall),
      .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // gap, rep, edges to first training (0 = none), sequence length, cfg_err
   localparam int NV = 7;
   localparam int V_GAP [NV] = '{32, 36, 0, 40, 50, 28, 64};
   localparam int V_REP [NV] = '{ 2,  1, 3,  0,  1,  1,  3};
   localparam int V_FST [NV] = '{32, 36, 0,  0,  0,  0, 64};
   localparam int V_LEN [NV] = '{ 8,  4, 0,  0,  0,  0, 12};
   localparam int V_ERR [NV] = '{ 0,  0, 0,  0,  1,  1,  0};

   // Count edges from enable until training, driving one data burst from edge 29.
   task automatic burst_run(input bit sop, input bit hen, output int n);
      link_en = 1'b0; hold_en = hen; min_blk = 9'd2;
      max_gap = 16'd32; rep_cnt = 16'd1;
      @(negedge clk); link_en = 1'b1;
      n = 0;
      while (!trn_act && n < 300) begin
         @(negedge clk); n++;
         if (n == 29) begin dat_vld = 1'b1; dat_sop = sop; end
         else if (n == 30) dat_sop = 1'b0;
      end
      dat_vld = 1'b0; dat_sop = 1'b0; link_en = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #2000000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int n, len, rq, gap, sbad, seen;
      link_en = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(trn_act == 0 && trn_req == 0 && dat_stall == 0, "R1 reset", int'(trn_act), 0);
      rst_n = 1'b1; link_en = 1'b0;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         link_en = 1'b0; max_gap = 16'(V_GAP[v]); rep_cnt = 16'(V_REP[v]);
         @(negedge clk); link_en = 1'b1;
         n = 0; sbad = 0; seen = 0;
         while (n < 200 && seen == 0) begin
            @(negedge clk); n++;
            if (n == 1) chk(cfg_err == V_ERR[v][0], "R5 cfg_err", int'(cfg_err), V_ERR[v]);
            if (dat_stall !== trn_act) sbad++;
            if (trn_act) seen = 1;
         end
         if (V_FST[v] == 0) begin
            chk(seen == 0, "R4/R5 no periodic training", seen, 0);
         end else begin
            chk(n == V_FST[v], "R2 first interval", n, V_FST[v]);
            len = 0; rq = 0;
            while (trn_act && len < 1000) begin
               if (trn_req) rq++;
               len++;
               @(negedge clk);
               if (dat_stall !== trn_act) sbad++;
            end
            chk(len == V_LEN[v], "R3 sequence length", len, V_LEN[v]);
            chk(rq == 1, "R3 single request strobe", rq, 1);
            gap = 0;
            while (!trn_act && gap < 1000) begin
               gap++;
               @(negedge clk);
               if (dat_stall !== trn_act) sbad++;
            end
            chk(gap == V_GAP[v], "R2 repeat interval", gap, V_GAP[v]);
         end
         chk(sbad == 0, "R6 stall follows training", sbad, 0);
      end
      link_en = 1'b0;
      @(negedge clk);

      // R7: opening burst with hold-off: 8 beats from edge 30, training after edge 37
      burst_run(1'b1, 1'b1, n);
      chk(n == 37, "R7 hold-off on opening burst", n, 37);
      chk(n <= 32 + 8, "R9 stretch bound", n, 40);
      // R8: same burst without start-of-packet is cut on time
      burst_run(1'b0, 1'b1, n);
      chk(n == 32, "R8 non-opening burst cut", n, 32);
      // R8: hold-off disabled
      burst_run(1'b1, 1'b0, n);
      chk(n == 32, "R8 hold_en low no deferral", n, 32);

      // R1: dropping enable mid-interval restarts the count
      max_gap = 16'd32; rep_cnt = 16'd2;
      @(negedge clk); link_en = 1'b1;
      repeat (20) @(negedge clk);
      link_en = 1'b0;
      @(negedge clk); link_en = 1'b1;
      n = 0;
      while (!trn_act && n < 300) begin @(negedge clk); n++; end
      chk(n == 32, "R1 interval restarts after enable drop", n, 32);
      link_en = 1'b0;
      @(negedge clk);

      // R10: forced continuous training
      link_en = 1'b1;
      repeat (5) @(negedge clk);
      force_trn = 1'b1;
      @(negedge clk);
      force_trn = 1'b0;
      chk(trn_act == 1 && trn_req == 1, "R10 force starts next edge", int'(trn_act), 1);
      sbad = 0; rq = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!trn_act) sbad++;
         if (trn_req) rq++;
      end
      chk(sbad == 0, "R10 training continuous", sbad, 0);
      chk(rq == 5, "R10 strobe every sequence", rq, 5);
      link_en = 1'b0;
      @(negedge clk);
      chk(trn_act == 0, "R10 enable drop ends forced training", int'(trn_act), 0);
      link_en = 1'b1;
      n = 0;
      while (!trn_act && n < 300) begin @(negedge clk); n++; end
      chk(n == 32, "R10 periodic timing after re-enable", n, 32);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule